// File: doc/BRIEF.md
# Relative constant-register address resolver

This block turns the source operand field of a shader instruction into the four-component value that the datapath consumes. It accepts a 7-bit source index, a 2-bit selector that picks one of three signed address registers as an offset, and the current values of those address registers. From the index alone it decides which register class the operand names: the per-vertex input file, the temporary file or the constant file.

The offset is used only for constant reads. It is discarded when it does not fit a signed byte. Otherwise it is added to the constant number and the sum wraps to 7 bits. A wrapped number that lands beyond the last constant yields a fixed vector of four copies of 1.0 instead of register contents. The three register files sit inside the block. Each has one synchronous write port, and the read path is purely combinational.

Top module: `const_src_resolver`

## Requirements
- R1: After reset every entry of all three files reads as zero.
- R2: Source index 0x00–0x0F reads input entry idx with rd_kind 0; 0x10–0x1F reads temporary entry idx-16 with rd_kind 1; 0x20–0x7F reads constant entry idx-32 with rd_kind 2. The value appears on rd_data in the same cycle as the index.
- R3: For input and temporary operands the selected offset has no effect; the offset is taken as zero.
- R4: idx_sel 0 gives no offset, 1 uses addr_x, 2 uses addr_y, 3 uses addr_loop.
- R5: A selected offset below -128 or above 127 is replaced by zero.
- R6: The constant number (idx-32) plus the offset is taken modulo 128. For example, constant 90 with offset +40 reads constant 2, and constant 0 with offset -128 reads constant 0.
- R7: When the wrapped constant number exceeds 95, rd_data is four copies of 32'h3F800000 (1.0, component 0 in the low bits) and rd_oob is 1. Otherwise rd_oob is 0.
- R8: With wr_en high at a rising edge, wr_data is stored at wr_addr in the file named by wr_file (0 input, 1 temporary, 2 constant). wr_file 3 stores nothing.
- R9: A write whose wr_addr is not below the depth of the target file (16, 16 or 96) changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_idx | input | 7 | Source operand register number |
| idx_sel | input | 2 | Offset source select |
| addr_x | input | 32 | First address register, signed |
| addr_y | input | 32 | Second address register, signed |
| addr_loop | input | 32 | Loop counter register, signed |
| wr_en | input | 1 | Write enable |
| wr_file | input | 2 | Write target file |
| wr_addr | input | 7 | Entry number within the target file |
| wr_data | input | 128 | Four 32-bit components to store |
| rd_data | output | 128 | Resolved operand value |
| rd_kind | output | 2 | Register class of the operand |
| rd_oob | output | 1 | Wrapped constant number past the last entry |

## Verification
The bench targets offsets at and just beyond the signed-byte limits (127, 128, -128, -129). A design that clamps such values instead of dropping them would read a constant near the edge rather than the unshifted one. Sums that cross 127 or fall below zero check the 7-bit wrap. A design that saturates or sign-extends there would return the all-ones default or a wrong entry. An offset paired with an input or temporary index must still return the unshifted entry. Writes aimed past a file's depth are followed by a full sweep of every entry, which catches an aliased write into a low entry.

// File: rtl/csr_pkg.sv
package csr_pkg;
  typedef enum logic [1:0] {
    SK_INPUT = 2'd0,
    SK_TEMP  = 2'd1,
    SK_CONST = 2'd2
  } src_kind_e;

  typedef enum logic [1:0] {
    WF_INPUT = 2'd0,
    WF_TEMP  = 2'd1,
    WF_CONST = 2'd2,
    WF_NONE  = 2'd3
  } wr_file_e;
endpackage

// File: rtl/csr_offset_sel.sv
module csr_offset_sel #(
  parameter int AW    = 32,
  parameter int OFS_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              sel,
  input  logic signed [AW-1:0]    ax,
  input  logic signed [AW-1:0]    ay,
  input  logic signed [AW-1:0]    al,
  output logic signed [OFS_W-1:0] off
);
  localparam logic signed [AW-1:0] LIM_HI = AW'((2 ** (OFS_W - 1)) - 1);
  localparam logic signed [AW-1:0] LIM_LO = ~LIM_HI;

  logic signed [AW-1:0] raw;
  logic                 in_rng;

  always_comb begin
    case (sel)
      2'd1:    raw = ax;
      2'd2:    raw = ay;
      2'd3:    raw = al;
      default: raw = '0;
    endcase
    in_rng = (raw <= LIM_HI) && (raw >= LIM_LO);
    off    = in_rng ? raw[OFS_W-1:0] : '0;
  end

  // R5: a wide offset never leaks through
  a_r5_wide_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel != 2'd0) && ((raw > LIM_HI) || (raw < LIM_LO))) |-> (off == '0));
  // R4: no offset when nothing is selected
  a_r4_none_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'd0) |-> (off == '0));
endmodule

// File: rtl/csr_regfile.sv
module csr_regfile #(
  parameter int DEPTH = 16,
  parameter int AW    = 7,
  parameter int DW    = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int            IW      = $clog2(DEPTH);
  localparam logic [AW-1:0] DEPTH_A = AW'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] mem_d [DEPTH];
  logic          wr_ok;

  always_comb begin
    wr_ok = we && (waddr < DEPTH_A);
    mem_d = mem_q;
    if (wr_ok) mem_d[waddr[IW-1:0]] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q <= mem_d;
    end
  end

  always_comb rdata = (raddr < DEPTH_A) ? mem_q[raddr[IW-1:0]] : '0;

  // R8: an accepted write is held at its entry afterwards
  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (waddr < DEPTH_A)) |=> (mem_q[$past(waddr[IW-1:0])] == $past(wdata)));
endmodule

// File: rtl/const_src_resolver.sv
module const_src_resolver
  import csr_pkg::*;
#(
  parameter int            DW      = 32,
  parameter int            NCOMP   = 4,
  parameter int            AW      = 32,
  parameter int            IDX_W   = 7,
  parameter int            N_IN    = 16,
  parameter int            N_TMP   = 16,
  parameter int            N_CST   = 96,
  parameter int            OFS_W   = 8,
  parameter logic [DW-1:0] ONE_VAL = 32'h3F80_0000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [IDX_W-1:0]        src_idx,
  input  logic [1:0]              idx_sel,
  input  logic signed [AW-1:0]    addr_x,
  input  logic signed [AW-1:0]    addr_y,
  input  logic signed [AW-1:0]    addr_loop,
  input  logic                    wr_en,
  input  logic [1:0]              wr_file,
  input  logic [IDX_W-1:0]        wr_addr,
  input  logic [DW*NCOMP-1:0]     wr_data,
  output logic [DW*NCOMP-1:0]     rd_data,
  output logic [1:0]              rd_kind,
  output logic                    rd_oob
);
  localparam int               VW       = DW * NCOMP;
  localparam logic [IDX_W-1:0] TMP_BASE = IDX_W'(N_IN);
  localparam logic [IDX_W-1:0] CST_BASE = IDX_W'(N_IN + N_TMP);
  localparam logic [IDX_W-1:0] CST_LAST = IDX_W'(N_CST - 1);
  localparam logic [VW-1:0]    ONES_V   = {NCOMP{ONE_VAL}};

  src_kind_e               kind;
  logic signed [OFS_W-1:0] off_sel;
  logic signed [OFS_W-1:0] off_eff;
  logic [IDX_W-1:0]        tmp_ra;
  logic [IDX_W-1:0]        cst_idx;
  logic [VW-1:0]           in_rd, tmp_rd, cst_rd;
  logic                    we_in, we_tmp, we_cst;

  csr_offset_sel #(.AW(AW), .OFS_W(OFS_W)) u_ofs (
    .clk(clk), .rst_n(rst_n), .sel(idx_sel),
    .ax(addr_x), .ay(addr_y), .al(addr_loop), .off(off_sel)
  );

  always_comb begin
    if (src_idx < TMP_BASE)      kind = SK_INPUT;
    else if (src_idx < CST_BASE) kind = SK_TEMP;
    else                         kind = SK_CONST;
    off_eff = (kind == SK_CONST) ? off_sel : '0;
    tmp_ra  = src_idx - TMP_BASE;
    cst_idx = (src_idx - CST_BASE) + IDX_W'(off_eff);
    rd_oob  = (kind == SK_CONST) && (cst_idx > CST_LAST);
    case (kind)
      SK_INPUT: rd_data = in_rd;
      SK_TEMP:  rd_data = tmp_rd;
      default:  rd_data = rd_oob ? ONES_V : cst_rd;
    endcase
    rd_kind = kind;
  end

  always_comb begin
    we_in  = wr_en && (wr_file == WF_INPUT);
    we_tmp = wr_en && (wr_file == WF_TEMP);
    we_cst = wr_en && (wr_file == WF_CONST);
  end

  csr_regfile #(.DEPTH(N_IN), .AW(IDX_W), .DW(VW)) u_in_file (
    .clk(clk), .rst_n(rst_n), .we(we_in), .waddr(wr_addr), .wdata(wr_data),
    .raddr(src_idx), .rdata(in_rd)
  );

  csr_regfile #(.DEPTH(N_TMP), .AW(IDX_W), .DW(VW)) u_tmp_file (
    .clk(clk), .rst_n(rst_n), .we(we_tmp), .waddr(wr_addr), .wdata(wr_data),
    .raddr(tmp_ra), .rdata(tmp_rd)
  );

  csr_regfile #(.DEPTH(N_CST), .AW(IDX_W), .DW(VW)) u_cst_file (
    .clk(clk), .rst_n(rst_n), .we(we_cst), .waddr(wr_addr), .wdata(wr_data),
    .raddr(cst_idx), .rdata(cst_rd)
  );

  // R7: the default vector accompanies the out-of-range flag
  a_r7_oob_ones: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oob |-> (rd_data == ONES_V));
  // R3: non-constant operands never reach the bounds check
  a_r3_nonconst_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_kind != SK_CONST) |-> !rd_oob);
  // R2: low indices always resolve to the input file
  a_r2_input_decode: assert property (@(posedge clk) disable iff (!rst_n)
    (src_idx < TMP_BASE) |-> (rd_kind == SK_INPUT));
endmodule

// File: tb/const_src_resolver_bench.sv
`timescale 1ns/1ps
module const_src_resolver_bench;
  logic               clk = 1'b0;
  logic               rst_n;
  logic [6:0]         src_idx;
  logic [1:0]         idx_sel;
  logic signed [31:0] addr_x, addr_y, addr_loop;
  logic               wr_en;
  logic [1:0]         wr_file;
  logic [6:0]         wr_addr;
  logic [127:0]       wr_data;
  logic [127:0]       rd_data;
  logic [1:0]         rd_kind;
  logic               rd_oob;

  int n_chk  = 0;
  int n_fail = 0;

  logic [127:0] inp_m [16];
  logic [127:0] tmp_m [16];
  logic [127:0] cst_m [96];

  localparam logic [127:0] ONES = {4{32'h3F80_0000}};

  always #2.5 clk = ~clk;

  const_src_resolver u_const_src_resolver (
    .clk(clk), .rst_n(rst_n), .src_idx(src_idx), .idx_sel(idx_sel),
    .addr_x(addr_x), .addr_y(addr_y), .addr_loop(addr_loop),
    .wr_en(wr_en), .wr_file(wr_file), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_data(rd_data), .rd_kind(rd_kind), .rd_oob(rd_oob)
  );

  function automatic void model_rd(input int idx, input int sel, input int ax,
                                   input int ay, input int al,
                                   output logic [127:0] d, output int k,
                                   output bit oob);
    int off;
    int ci;
    oob = 1'b0;
    if (idx < 16) begin
      k = 0; d = inp_m[idx];
    end else if (idx < 32) begin
      k = 1; d = tmp_m[idx-16];
    end else begin
      k = 2;
      case (sel)
        0:       off = 0;
        1:       off = ax;
        2:       off = ay;
        default: off = al;
      endcase
      if (off < -128 || off > 127) off = 0;
      ci = (idx - 32 + off) & 127;
      if (ci > 95) begin oob = 1'b1; d = ONES; end
      else d = cst_m[ci];
    end
  endfunction

  task automatic rd_check(input int idx, input int sel, input int ax,
                          input int ay, input int al, input string req);
    logic [127:0] ed;
    int ek;
    bit eo;
    @(negedge clk);
    src_idx = 7'(idx); idx_sel = 2'(sel);
    addr_x = ax; addr_y = ay; addr_loop = al;
    #1;
    model_rd(idx, sel, ax, ay, al, ed, ek, eo);
    n_chk++;
    if (rd_data !== ed || rd_kind !== 2'(ek) || rd_oob !== eo) begin
      n_fail++;
      $display("FAIL %s idx=%0d sel=%0d: got data=%h kind=%0d oob=%0b, expected data=%h kind=%0d oob=%0b",
               req, idx, sel, rd_data, rd_kind, rd_oob, ed, ek, eo);
    end
  endtask

  task automatic wr(input int f, input int a, input logic [127:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_file = 2'(f); wr_addr = 7'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (f == 0 && a < 16) inp_m[a] = d;
    if (f == 1 && a < 16) tmp_m[a] = d;
    if (f == 2 && a < 96) cst_m[a] = d;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic int rnd_ofs();
    if ($urandom_range(0, 3) == 0) return int'($urandom);
    return int'($urandom_range(0, 400)) - 200;
  endfunction

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20231002));
    for (int i = 0; i < 16; i++) begin inp_m[i] = '0; tmp_m[i] = '0; end
    for (int i = 0; i < 96; i++) cst_m[i] = '0;
    rst_n = 1'b0; wr_en = 1'b0; wr_file = 2'd3; wr_addr = '0; wr_data = '0;
    src_idx = '0; idx_sel = '0; addr_x = 0; addr_y = 0; addr_loop = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: everything reads zero after reset
    rd_check(0, 0, 0, 0, 0, "R1");
    rd_check(21, 0, 0, 0, 0, "R1");
    rd_check(32, 0, 0, 0, 0, "R1");
    rd_check(127, 0, 0, 0, 0, "R1");

    // R8: fill every file
    for (int i = 0; i < 16; i++) wr(0, i, rnd128());
    for (int i = 0; i < 16; i++) wr(1, i, rnd128());
    for (int i = 0; i < 96; i++) wr(2, i, rnd128());
    rd_check(5, 0, 0, 0, 0, "R8");
    rd_check(16 + 9, 0, 0, 0, 0, "R8");
    rd_check(32 + 40, 0, 0, 0, 0, "R8");

    // R2: each class
    rd_check(3, 0, 0, 0, 0, "R2");
    rd_check(15, 0, 0, 0, 0, "R2");
    rd_check(16, 0, 0, 0, 0, "R2");
    rd_check(31, 0, 0, 0, 0, "R2");
    rd_check(42, 0, 0, 0, 0, "R2");

    // R3: offsets ignored on inputs and temporaries
    rd_check(2, 1, 5, 0, 0, "R3");
    rd_check(20, 2, 0, -3, 0, "R3");
    rd_check(31, 3, 0, 0, 1, "R3");

    // R4: each selector value on c8
    rd_check(40, 0, 1, 3, 7, "R4");
    rd_check(40, 1, 1, 3, 7, "R4");
    rd_check(40, 2, 1, 3, 7, "R4");
    rd_check(40, 3, 1, 3, 7, "R4");

    // R5: signed-byte limits
    rd_check(33, 1, 127, 0, 0, "R5");
    rd_check(33, 1, 128, 0, 0, "R5");
    rd_check(33, 2, 0, -128, 0, "R5");
    rd_check(33, 2, 0, -129, 0, "R5");
    rd_check(50, 3, 0, 0, 32'sh7FFF_FFFF, "R5");

    // R6: 7-bit wrap
    rd_check(32 + 90, 1, 40, 0, 0, "R6");
    rd_check(32, 1, -128, 0, 0, "R6");
    rd_check(32 + 10, 2, 0, -20, 0, "R6");

    // R7: past the last constant
    rd_check(32, 1, -1, 0, 0, "R7");
    rd_check(32 + 95, 1, 1, 0, 0, "R7");
    rd_check(32 + 95, 1, 0, 0, 0, "R7");

    // R8: file code 3 writes nothing
    wr(3, 5, rnd128());
    rd_check(5, 0, 0, 0, 0, "R8");
    rd_check(16 + 5, 0, 0, 0, 0, "R8");
    rd_check(32 + 5, 0, 0, 0, 0, "R8");

    // R9: writes beyond depth, then sweep everything
    wr(2, 96, rnd128());
    wr(2, 127, rnd128());
    wr(0, 16, rnd128());
    wr(0, 80, rnd128());
    wr(1, 20, rnd128());
    for (int i = 0; i < 128; i++) rd_check(i, 0, 0, 0, 0, "R9");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 15) == 0)
        wr(int'($urandom_range(0, 3)), int'($urandom_range(0, 127)), rnd128());
      rd_check(int'($urandom_range(0, 127)), int'($urandom_range(0, 3)),
               rnd_ofs(), rnd_ofs(), rnd_ofs(), "R6");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule